// File: doc/BRIEF.md
# Code-Selected Multiply-Add Datapath

This block is a pipelined signed arithmetic unit for filter and accumulator chains. A 7-bit operation code, sampled every cycle, picks three adder operands (X, Y, Z) from a set of sources: zero, the product of the signed 18-bit inputs A and B, the 36-bit concatenation A:B, the 48-bit C input, a 48-bit cascade input from a neighbouring unit, the unit's own result P, and arithmetic right shifts by 17 bits of the cascade input or of P. The unit then computes either Z + (X + Y + carry-in) or Z - (X + Y + carry-in) and stores the result in a 48-bit P register. That result goes to the P output and to a cascade output for the next unit.

A and B each pass through an input register chain of depth IN_DEPTH (0 to 2), and each chain has its own clock enable. The product and A:B then pass through an optional M stage (M_EN) with a clock enable. The P register has its own enable. The operation code, the subtract and carry controls, C and the cascade input are delayed by the same number of stages, so each code acts on the operands that were presented with it. The code can change on any cycle, so one unit can multiply in one cycle and accumulate in the next. An unlisted code raises a registered error flag and leaves P unchanged.

Top module: `mac_opsel_unit`

## Requirements
- R1: After reset, p_o, pcout_o and err_o are all zero.
- R2: Code bits [1:0] pick X: 00 zero, 10 P, 11 A:B sign-extended from the MSB of A, 01 the product (legal only when bits [3:2] are also 01).
- R3: Code bits [3:2] pick Y: 00 zero, 11 C, 01 the product pairing (the product is added once). The value 10 is illegal, and so is exactly one of X and Y being 01.
- R4: Code bits [6:4] pick Z: 000 zero, 001 cascade input, 010 P, 011 C, 101 cascade input arithmetic-shifted right by 17, 110 P arithmetic-shifted right by 17. The values 100 and 111 are illegal.
- R5: With sub_i low the result is Z + X + Y + cin_i. With sub_i high it is Z - (X + Y + cin_i). Both wrap modulo 2^48.
- R6: With the default parameters (IN_DEPTH=1, M_EN=1) and all enables high, inputs presented before rising edge k appear on p_o after edge k+2. A different code may be presented every cycle.
- R7: P feedback uses the value P held before the edge that writes the new result, so code 0100101 accumulates A*B on each cycle.
- R8: While ce_p_i is low at an edge, p_o and err_o keep their values.
- R9: An illegal code reaching the P stage with ce_p_i high sets err_o and leaves p_o unchanged. A legal code clears err_o.
- R10: pcout_o always equals p_o.
- R11: The product is the signed two's complement A*B, sign-extended to 48 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_a_i | input | 1 | Enable for the A input registers |
| ce_b_i | input | 1 | Enable for the B input registers |
| ce_m_i | input | 1 | Enable for the product stage |
| ce_p_i | input | 1 | Enable for P and the error flag |
| a_i | input | 18 | Signed operand A |
| b_i | input | 18 | Signed operand B |
| c_i | input | 48 | Operand C |
| pcin_i | input | 48 | Cascade input from the previous unit |
| opsel_i | input | 7 | Operation code {Z[2:0], Y[1:0], X[1:0]} |
| sub_i | input | 1 | Subtract select |
| cin_i | input | 1 | Carry-in |
| p_o | output | 48 | Result register |
| pcout_o | output | 48 | Cascade output, copy of P |
| err_o | output | 1 | Registered flag for an illegal code |

## Verification
Directed sequences apply each X, Y and Z source alone and check the exact result. They use negative A and B to tell sign extension from zero extension, and a negative cascade value and a negative P to tell an arithmetic shift from a logical one. A run of multiply-accumulate codes and a code that changes every cycle tell correct feedback timing and operand alignment apart from a pipeline that is off by one stage. Random legal and illegal codes, subtract, carry and P enable values are then compared each cycle against a bench model, which separates the hold-on-illegal and hold-on-disable behaviours from normal updates.

// File: rtl/mac_opsel_pkg.sv
package mac_opsel_pkg;
  localparam int P_W   = 48;
  localparam int OP_W  = 7;
  localparam int SHIFT = 17;

  typedef logic [P_W-1:0] word_t;

  typedef struct packed {
    logic [OP_W-1:0] op;
    logic            sub;
    logic            cin;
    word_t           c;
    word_t           pcin;
  } ctl_t;

  typedef enum logic [1:0] {X_ZERO = 2'b00, X_PROD = 2'b01, X_P = 2'b10, X_AB = 2'b11} xsel_e;
  typedef enum logic [1:0] {Y_ZERO = 2'b00, Y_PROD = 2'b01, Y_RSVD = 2'b10, Y_C = 2'b11} ysel_e;
  typedef enum logic [2:0] {
    Z_ZERO = 3'd0, Z_CAS = 3'd1, Z_P = 3'd2, Z_C = 3'd3,
    Z_RSV4 = 3'd4, Z_CAS_SH = 3'd5, Z_P_SH = 3'd6, Z_RSV7 = 3'd7
  } zsel_e;
endpackage

// File: rtl/mac_pipe_reg.sv
module mac_pipe_reg #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] stg_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
      end else if (ce_i) begin
        stg_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
      end
    end
    assign q_o = stg_q[DEPTH-1];
  end
endmodule

// File: rtl/mac_operand_mux.sv
module mac_operand_mux
  import mac_opsel_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  word_t           prod_i,
  input  word_t           ab_i,
  input  word_t           c_i,
  input  word_t           pcin_i,
  input  word_t           p_i,
  output word_t           x_o,
  output word_t           y_o,
  output word_t           z_o,
  output logic            valid_o
);
  xsel_e xs;
  ysel_e ys;
  zsel_e zs;
  logic  xy_ok, z_ok;

  assign xs = xsel_e'(op_i[1:0]);
  assign ys = ysel_e'(op_i[3:2]);
  assign zs = zsel_e'(op_i[6:4]);

  always_comb begin
    case (xs)
      X_PROD:  x_o = prod_i;
      X_P:     x_o = p_i;
      X_AB:    x_o = ab_i;
      default: x_o = '0;
    endcase
    // product travels on X only; the paired Y code contributes zero
    case (ys)
      Y_C:     y_o = c_i;
      default: y_o = '0;
    endcase
    case (zs)
      Z_CAS:    z_o = pcin_i;
      Z_P:      z_o = p_i;
      Z_C:      z_o = c_i;
      Z_CAS_SH: z_o = word_t'($signed(pcin_i) >>> SHIFT);
      Z_P_SH:   z_o = word_t'($signed(p_i) >>> SHIFT);
      default:  z_o = '0;
    endcase
  end

  assign xy_ok   = ((xs == X_PROD) == (ys == Y_PROD)) && (ys != Y_RSVD);
  assign z_ok    = (zs != Z_RSV4) && (zs != Z_RSV7);
  assign valid_o = xy_ok && z_ok;
endmodule

// File: rtl/mac_post_adder.sv
module mac_post_adder
  import mac_opsel_pkg::*;
(
  input  word_t x_i,
  input  word_t y_i,
  input  word_t z_i,
  input  logic  cin_i,
  input  logic  sub_i,
  output word_t res_o
);
  word_t sum;
  assign sum   = x_i + y_i + word_t'(cin_i);
  assign res_o = sub_i ? (z_i - sum) : (z_i + sum);
endmodule

// File: rtl/mac_opsel_unit.sv
module mac_opsel_unit
  import mac_opsel_pkg::*;
#(
  parameter int A_W      = 18,
  parameter int B_W      = 18,
  parameter int IN_DEPTH = 1,
  parameter int M_EN     = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ce_a_i,
  input  logic            ce_b_i,
  input  logic            ce_m_i,
  input  logic            ce_p_i,
  input  logic [A_W-1:0]  a_i,
  input  logic [B_W-1:0]  b_i,
  input  logic [P_W-1:0]  c_i,
  input  logic [P_W-1:0]  pcin_i,
  input  logic [OP_W-1:0] opsel_i,
  input  logic            sub_i,
  input  logic            cin_i,
  output logic [P_W-1:0]  p_o,
  output logic [P_W-1:0]  pcout_o,
  output logic            err_o
);
  localparam int PR_W  = A_W + B_W;
  localparam int CTL_W = $bits(ctl_t);
  localparam int M_DEP = (M_EN != 0) ? 1 : 0;

  logic [A_W-1:0]        a_q;
  logic [B_W-1:0]        b_q;
  logic signed [PR_W-1:0] prod;
  logic [2*PR_W-1:0]     m_d, m_q;
  ctl_t                  ctl_in, ctl_mid, ctl_s;
  word_t                 prod_x, ab_x, x, y, z, res, p_q;
  logic [OP_W-1:0]       op_s;
  logic                  sub_s, cin_s, valid, err_q;

  mac_pipe_reg #(.W(A_W), .DEPTH(IN_DEPTH)) u_areg (
    .clk_i, .rst_ni, .ce_i(ce_a_i), .d_i(a_i), .q_o(a_q));
  mac_pipe_reg #(.W(B_W), .DEPTH(IN_DEPTH)) u_breg (
    .clk_i, .rst_ni, .ce_i(ce_b_i), .d_i(b_i), .q_o(b_q));

  assign ctl_in = '{op: opsel_i, sub: sub_i, cin: cin_i, c: c_i, pcin: pcin_i};

  // control and side operands track the operand pipeline depth
  mac_pipe_reg #(.W(CTL_W), .DEPTH(IN_DEPTH)) u_ctl_in (
    .clk_i, .rst_ni, .ce_i(1'b1), .d_i(ctl_in), .q_o(ctl_mid));
  mac_pipe_reg #(.W(CTL_W), .DEPTH(M_DEP)) u_ctl_m (
    .clk_i, .rst_ni, .ce_i(1'b1), .d_i(ctl_mid), .q_o(ctl_s));

  assign prod = $signed(a_q) * $signed(b_q);
  assign m_d  = {prod, a_q, b_q};

  mac_pipe_reg #(.W(2*PR_W), .DEPTH(M_DEP)) u_mreg (
    .clk_i, .rst_ni, .ce_i(ce_m_i), .d_i(m_d), .q_o(m_q));

  assign prod_x = {{(P_W-PR_W){m_q[2*PR_W-1]}}, m_q[2*PR_W-1:PR_W]};
  assign ab_x   = {{(P_W-PR_W){m_q[PR_W-1]}}, m_q[PR_W-1:0]};

  assign op_s  = ctl_s.op;
  assign sub_s = ctl_s.sub;
  assign cin_s = ctl_s.cin;

  mac_operand_mux u_mux (
    .op_i(op_s), .prod_i(prod_x), .ab_i(ab_x), .c_i(ctl_s.c), .pcin_i(ctl_s.pcin),
    .p_i(p_q), .x_o(x), .y_o(y), .z_o(z), .valid_o(valid));

  mac_post_adder u_add (
    .x_i(x), .y_i(y), .z_i(z), .cin_i(cin_s), .sub_i(sub_s), .res_o(res));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q   <= '0;
      err_q <= 1'b0;
    end else if (ce_p_i) begin
      err_q <= !valid;
      if (valid) p_q <= res;
    end
  end

  assign p_o     = p_q;
  assign pcout_o = p_q;
  assign err_o   = err_q;
endmodule

// File: rtl/mac_opsel_checker.sv
module mac_opsel_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_p_i,
  input logic [6:0]  op_q,
  input logic        sub_q,
  input logic        cin_q,
  input logic [47:0] p_o,
  input logic        err_o
);
  logic bad;
  assign bad = (op_q[6:4] == 3'b100) || (op_q[6:4] == 3'b111) || (op_q[3:2] == 2'b10) ||
               ((op_q[1:0] == 2'b01) != (op_q[3:2] == 2'b01));

  // R8
  p_hold_ce_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_p_i |=> ($stable(p_o) && $stable(err_o)));
  // R9
  p_illegal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_p_i && bad) |=> (err_o && $stable(p_o)));
  p_legal_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_p_i && !bad) |=> !err_o);
  // R5
  p_zero_op_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_p_i && op_q == 7'b0000000 && !sub_q && !cin_q) |=> (p_o == 48'd0));
  // R7
  p_keep_p_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_p_i && op_q == 7'b0100000 && !cin_q) |=> $stable(p_o));
endmodule

bind mac_opsel_unit mac_opsel_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_p_i(ce_p_i), .op_q(op_s), .sub_q(sub_s),
  .cin_q(cin_s), .p_o(p_o), .err_o(err_o));

// File: tb/mac_opsel_unit_test.sv
module mac_opsel_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_a = 1'b1, ce_b = 1'b1, ce_m = 1'b1, ce_p = 1'b1;
  logic [17:0] a = '0, b = '0;
  logic [47:0] c = '0, pcin = '0;
  logic [6:0]  op = '0;
  logic        sub = 1'b0, cin = 1'b0;
  logic [47:0] p, pcout;
  logic        err;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [6:0]  op;
    logic        sub, cin, cep;
    logic [17:0] a, b;
    logic [47:0] c, pcin;
  } rec_t;

  rec_t        hist0, hist1;
  logic [47:0] m_p = '0;
  logic        m_err = 1'b0;

  always #5 clk = ~clk;

  mac_opsel_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_a_i(ce_a), .ce_b_i(ce_b), .ce_m_i(ce_m),
    .ce_p_i(ce_p), .a_i(a), .b_i(b), .c_i(c), .pcin_i(pcin), .opsel_i(op),
    .sub_i(sub), .cin_i(cin), .p_o(p), .pcout_o(pcout), .err_o(err));

  function automatic logic [47:0] sx36(input logic [35:0] v);
    return {{12{v[35]}}, v};
  endfunction

  function automatic logic legal(input logic [6:0] o);
    logic xy;
    xy = (o[3:0] == 4'b0101) ||
         ((o[1:0] != 2'b01) && (o[3:2] == 2'b00 || o[3:2] == 2'b11));
    return xy && !(o[6:4] == 3'd4 || o[6:4] == 3'd7);
  endfunction

  function automatic logic [47:0] model(input rec_t r, input logic [47:0] pp);
    logic signed [35:0] pr;
    logic [47:0] xv, yv, zv, s;
    pr = $signed(r.a) * $signed(r.b);
    xv = (r.op[1:0] == 2'b01) ? sx36(pr) : (r.op[1:0] == 2'b10) ? pp :
         (r.op[1:0] == 2'b11) ? sx36({r.a, r.b}) : 48'd0;
    yv = (r.op[3:2] == 2'b11) ? r.c : 48'd0;
    case (r.op[6:4])
      3'd1: zv = r.pcin;
      3'd2: zv = pp;
      3'd3: zv = r.c;
      3'd5: zv = 48'($signed(r.pcin) >>> 17);
      3'd6: zv = 48'($signed(pp) >>> 17);
      default: zv = 48'd0;
    endcase
    s = xv + yv + {47'd0, r.cin};
    return r.sub ? zv - s : zv + s;
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [48:0] act, input logic [48:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, then compare after the edge
  task automatic cyc(input rec_t r, input string tag);
    op = r.op; sub = r.sub; cin = r.cin; ce_p = r.cep;
    a = r.a; b = r.b; c = r.c; pcin = r.pcin;
    @(posedge clk);
    #1;
    if (r.cep) begin
      m_err = !legal(hist1.op);
      if (legal(hist1.op)) m_p = model(hist1, m_p);
    end
    chk(tag, {err, p}, {m_err, m_p});
    chk("R10", {1'b0, pcout}, {1'b0, p});
    hist1 = hist0;
    hist0 = r;
    @(negedge clk);
  endtask

  function automatic rec_t mk(input logic [6:0] o, input logic s, input logic ci,
                              input logic [17:0] av, input logic [17:0] bv,
                              input logic [47:0] cv, input logic [47:0] pv);
    rec_t r;
    r.op = o; r.sub = s; r.cin = ci; r.cep = 1'b1;
    r.a = av; r.b = bv; r.c = cv; r.pcin = pv;
    return r;
  endfunction

  task automatic flush(input string tag);
    for (int i = 0; i < 2; i++) cyc(mk(7'b0100000, 0, 0, 0, 0, 0, 0), tag);
  endtask

  function automatic logic [6:0] rand_op();
    logic [3:0] xy [7] = '{4'b0000, 4'b0010, 4'b0011, 4'b1100, 4'b1110, 4'b1111, 4'b0101};
    logic [2:0] zz [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd6};
    if ($urandom_range(15) == 0) return 7'($urandom);
    return {zz[$urandom_range(5)], xy[$urandom_range(6)]};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    rec_t r;
    void'($urandom(32'h5eed_1234));
    hist0 = mk(0, 0, 0, 0, 0, 0, 0);
    hist1 = hist0;
    a = 18'h3ffff; c = 48'hffff;
    repeat (3) @(negedge clk);
    chk("R1", {err, p}, 49'd0);
    chk("R1", {1'b0, pcout}, 49'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: A:B on X, positive and negative A
    cyc(mk(7'b0000011, 0, 0, 18'd1, 18'd2, 0, 0), "R2");
    cyc(mk(7'b0000011, 0, 0, 18'h3fffe, 18'd7, 0, 0), "R2");
    flush("R2");
    // R11: signed products
    cyc(mk(7'b0000101, 0, 0, 18'h3fffd, 18'd5, 0, 0), "R11");
    cyc(mk(7'b0000101, 0, 0, 18'h20000, 18'h20000, 0, 0), "R11");
    cyc(mk(7'b0000101, 0, 0, 18'h1ffff, 18'h3ffff, 0, 0), "R11");
    flush("R11");
    // R3: Y = C, Y = C with X = P
    cyc(mk(7'b0001100, 0, 0, 0, 0, 48'h1234_5678_9abc, 0), "R3");
    cyc(mk(7'b0001110, 0, 0, 0, 0, 48'd1, 0), "R3");
    flush("R3");
    // R4: each Z source, negative values for shifts
    cyc(mk(7'b0010000, 0, 0, 0, 0, 0, 48'h8000_0000_0000), "R4");
    cyc(mk(7'b1010000, 0, 0, 0, 0, 0, 48'h8000_0000_0000), "R4");
    cyc(mk(7'b0110000, 0, 0, 0, 0, 48'hf000_0000_0001, 0), "R4");
    flush("R4");
    cyc(mk(7'b1100000, 0, 0, 0, 0, 0, 0), "R4");
    cyc(mk(7'b0110011, 0, 1, 18'd3, 18'd4, 48'd9, 0), "R4");
    flush("R4");
    // R5: subtract with carry, C - (C + 1) = -1
    cyc(mk(7'b0111100, 1, 1, 0, 0, 48'd77, 0), "R5");
    cyc(mk(7'b0011111, 1, 0, 18'd1, 18'd1, 48'd5, 0), "R5");
    flush("R5");
    // R7: multiply-accumulate run
    cyc(mk(7'b0000000, 0, 0, 0, 0, 0, 0), "R7");
    for (int i = 1; i <= 6; i++)
      cyc(mk(7'b0100101, 0, 0, 18'(i), 18'h3fffd, 0, 0), "R7");
    flush("R7");
    // R6: code changes every cycle
    cyc(mk(7'b0110000, 0, 0, 0, 0, 48'd100, 0), "R6");
    cyc(mk(7'b0100101, 0, 0, 18'd2, 18'd3, 0, 0), "R6");
    cyc(mk(7'b0101100, 1, 0, 0, 0, 48'd50, 0), "R6");
    cyc(mk(7'b1100010, 0, 1, 0, 0, 0, 0), "R6");
    flush("R6");
    // R8: P enable low holds P and err
    r = mk(7'b0110000, 0, 0, 0, 0, 48'd999, 0);
    cyc(r, "R8");
    r.cep = 1'b0; r.op = 7'b0000011; r.a = 18'd5;
    cyc(r, "R8"); cyc(r, "R8"); cyc(r, "R8");
    flush("R8");
    // R9: illegal codes freeze P and flag, then legal clears
    cyc(mk(7'b0110000, 0, 0, 0, 0, 48'd31, 0), "R9");
    cyc(mk(7'b0000001, 0, 0, 18'd4, 18'd4, 0, 0), "R9");
    cyc(mk(7'b1000000, 0, 0, 0, 0, 0, 48'd8), "R9");
    cyc(mk(7'b0001000, 0, 0, 0, 0, 48'd8, 0), "R9");
    flush("R9");

    // R5: random mix against the bench model
    for (int i = 0; i < 3000; i++) begin
      r = mk(rand_op(), 1'($urandom), 1'($urandom), 18'($urandom), 18'($urandom),
             {16'($urandom), 32'($urandom)}, {16'($urandom), 32'($urandom)});
      r.cep = ($urandom_range(9) != 0);
      cyc(r, "R5");
    end
    report();
  end
endmodule